// File: doc/BRIEF.md
# Asynchronous SRAM Port with Early-Ready Countdown

This block sits between a processor's memory port and an external asynchronous static RAM of 32-bit words with a 15 ns access time, running at a 100 MHz system clock. The processor issues single-word reads and writes as one-cycle request pulses. The block launches the access on registers at the device pins and then reports a small busy value that counts down toward zero. The pipeline can therefore see exactly how many cycles remain and schedule its next step before the data arrives.

A read takes two clocks from acceptance to captured data. The read word is taken straight from the data pins into a register on the last cycle. A write also takes two clocks. The active-low write strobe is launched from the falling clock edge, so it opens half a cycle after the address settles and closes half a cycle before the address may move. With a strobe driven only on rising edges, the same safe window would need a third cycle. The block sets its own latency through the busy value; no wait-state count is configured from outside.

Top module: `asram_port`

## Requirements
- R1: While reset is high and after its release, busy is 0, chip enable, output enable and write strobe (all active low) are high, the data-pin drive enable is low and the read data register is 0.
- R2: A read request accepted at a rising edge loads busy with RD_CYC (default 2). Busy then falls by one per rising edge to 0, and the cycle busy reaches 0 the read data output holds the SRAM word at the requested address.
- R3: A write request accepted at a rising edge loads busy with WR_CYC (default 2), and busy falls by one per rising edge to 0. After completion, the SRAM word at that address equals the write data.
- R4: A request is accepted only while busy is 0. Requests seen while busy is non-zero leave busy, the SRAM contents and the access in progress unchanged.
- R5: When read and write requests are high in the same accepting cycle, the write is performed and the read is dropped.
- R6: The write strobe goes low on the falling edge that follows acceptance of a write. It returns high on the falling edge at which busy is 1, half a cycle before the access ends.
- R7: While the write strobe is low, chip enable is low and the data-pin drive enable is high, and the SRAM address and write data hold their values.
- R8: The data-pin drive enable is high only during a write, and output enable is low only during a read; the two are never active together.
- R9: The read data output changes only at the edge where a read completes. Writes and idle cycles leave it unchanged.
- R10: Whenever busy is 0, chip enable and output enable are high and the data-pin drive enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the write strobe also uses its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | AW | Word address of the request |
| cpu_rd | input | 1 | One-cycle read request |
| cpu_wr | input | 1 | One-cycle write request |
| cpu_wdata | input | DW | Write data |
| cpu_rdata | output | DW | Registered read data |
| cpu_busy | output | BW | Cycles left in the current access; 0 means ready |
| sram_addr | output | AW | Registered SRAM address pins |
| sram_dq_out | output | DW | Registered data driven toward the SRAM |
| sram_dq_oe | output | 1 | Drive enable for the data pins |
| sram_dq_in | input | DW | Data pins as seen from the SRAM |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low, launched from the falling edge |

## Verification
The assertions check the rules that must hold on every cycle: the steady one-step countdown of busy, the absence of bus contention, the idle pin state whenever busy is 0, and a stable address, data and chip enable under a low write strobe. They also check that the read register moves only on a read's final edge. Only the bench's scenarios can show that the right word comes back through the 15 ns SRAM model, that writes land at the right address, and that requests dropped while busy truly leave no trace. They also cover the exact half-cycle placement of the strobe and the write-over-read priority.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  function automatic int unsigned cnt_width(input int unsigned max_cycles);
    return (max_cycles < 1) ? 1 : $clog2(max_cycles + 1);
  endfunction
endpackage

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
// Access sequencer: owns the countdown and the kind of access in flight.
module asram_seq
  import asram_pkg::*;
#(
  parameter int RD_CYC = 2,
  parameter int WR_CYC = 2,
  parameter int BW     = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_req,
  input  logic          wr_req,
  output logic [BW-1:0] busy,
  output op_e           op,
  output logic          take_rd,
  output logic          take_wr,
  output logic          last,
  output logic          capture,
  output logic          we_window
);
  logic idle;

  always_comb begin
    idle      = (busy == '0);
    take_wr   = idle && wr_req;
    take_rd   = idle && rd_req && !wr_req;
    last      = (busy == BW'(1));
    capture   = last && (op == OP_READ);
    we_window = (op == OP_WRITE) && (busy > BW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= '0;
      op   <= OP_NONE;
    end else if (take_wr) begin
      busy <= BW'(WR_CYC);
      op   <= OP_WRITE;
    end else if (take_rd) begin
      busy <= BW'(RD_CYC);
      op   <= OP_READ;
    end else if (!idle) begin
      busy <= busy - BW'(1);
      if (last) op <= OP_NONE;
    end
  end
endmodule

// File: rtl/asram_pins.sv
`timescale 1ns/1ps
// Pin-side registers: address, data, controls and read capture.
module asram_pins #(
  parameter int AW = 18,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take_rd,
  input  logic          take_wr,
  input  logic          last,
  input  logic          capture,
  input  logic          we_window,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] dq_out_q,
  output logic          dq_oe_q,
  output logic          ce_n_q,
  output logic          oe_n_q,
  output logic          we_n_q,
  output logic [DW-1:0] rdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      dq_out_q <= '0;
      dq_oe_q  <= 1'b0;
      ce_n_q   <= 1'b1;
      oe_n_q   <= 1'b1;
    end else if (take_wr) begin
      addr_q   <= addr_in;
      dq_out_q <= wdata_in;
      dq_oe_q  <= 1'b1;
      ce_n_q   <= 1'b0;
      oe_n_q   <= 1'b1;
    end else if (take_rd) begin
      addr_q   <= addr_in;
      dq_oe_q  <= 1'b0;
      ce_n_q   <= 1'b0;
      oe_n_q   <= 1'b0;
    end else if (last) begin
      dq_oe_q  <= 1'b0;
      ce_n_q   <= 1'b1;
      oe_n_q   <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (capture) rdata_q <= dq_in;
  end

  // Strobe launched from the falling edge: opens half a cycle after the
  // address settles, closes half a cycle before it may move.
  always_ff @(negedge clk) begin
    if (rst) we_n_q <= 1'b1;
    else     we_n_q <= !we_window;
  end
endmodule

// File: rtl/asram_port.sv
`timescale 1ns/1ps
module asram_port
  import asram_pkg::*;
#(
  parameter int AW     = 18,
  parameter int DW     = 32,
  parameter int RD_CYC = 2,
  parameter int WR_CYC = 2,
  localparam int BW    = cnt_width((RD_CYC > WR_CYC) ? RD_CYC : WR_CYC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic [BW-1:0] cpu_busy,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_in,
  output logic          sram_ce_n,
  output logic          sram_oe_n,
  output logic          sram_we_n
);
  op_e  op_q;
  logic take_rd, take_wr, last, capture, we_window;

  asram_seq #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .BW(BW)) u_seq (
    .clk(clk), .rst(rst), .rd_req(cpu_rd), .wr_req(cpu_wr),
    .busy(cpu_busy), .op(op_q), .take_rd(take_rd), .take_wr(take_wr),
    .last(last), .capture(capture), .we_window(we_window)
  );

  asram_pins #(.AW(AW), .DW(DW)) u_pins (
    .clk(clk), .rst(rst), .take_rd(take_rd), .take_wr(take_wr),
    .last(last), .capture(capture), .we_window(we_window),
    .addr_in(cpu_addr), .wdata_in(cpu_wdata), .dq_in(sram_dq_in),
    .addr_q(sram_addr), .dq_out_q(sram_dq_out), .dq_oe_q(sram_dq_oe),
    .ce_n_q(sram_ce_n), .oe_n_q(sram_oe_n), .we_n_q(sram_we_n),
    .rdata_q(cpu_rdata)
  );
endmodule

// File: rtl/asram_port_chk.sv
`timescale 1ns/1ps
module asram_port_chk #(
  parameter int AW = 18,
  parameter int DW = 32,
  parameter int BW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [BW-1:0] busy,
  input logic [1:0]    op,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] dq_out,
  input logic          dq_oe,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic [DW-1:0] rdata
);
  // R2 R3 R4: once started, busy only counts down by one
  assert_countdown_R4: assert property (@(posedge clk) disable iff (rst)
    (busy != '0) |=> (busy == $past(busy) - BW'(1)));

  assert_idle_pins_R10: assert property (@(posedge clk) disable iff (rst)
    (busy == '0) |-> (ce_n && oe_n && !dq_oe));

  assert_no_contention_R8: assert property (@(posedge clk) disable iff (rst)
    !(dq_oe && !oe_n));

  assert_strobe_enabled_R7: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (!ce_n && dq_oe));

  assert_strobe_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !we_n |=> ($stable(addr) && $stable(dq_out)));

  assert_strobe_in_write_R6: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (op == asram_pkg::OP_WRITE));

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
    ((busy != BW'(1)) || (op != asram_pkg::OP_READ)) |=> $stable(rdata));
endmodule

bind asram_port asram_port_chk #(.AW(AW), .DW(DW), .BW(BW)) u_chk (
  .clk(clk), .rst(rst), .busy(cpu_busy), .op(op_q), .addr(sram_addr),
  .dq_out(sram_dq_out), .dq_oe(sram_dq_oe), .ce_n(sram_ce_n),
  .oe_n(sram_oe_n), .we_n(sram_we_n), .rdata(cpu_rdata)
);

// File: tb/sim_asram_port.sv
`timescale 1ns/1ps
module sim_asram_port;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int DEPTH = 1 << AW;
  localparam int BW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_rd = 1'b0;
  logic          cpu_wr = 1'b0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic [BW-1:0] cpu_busy;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] sram_dq_out;
  logic          sram_dq_oe;
  logic [DW-1:0] sram_dq_in;
  logic          sram_ce_n, sram_oe_n, sram_we_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  asram_port #(.AW(AW), .DW(DW), .RD_CYC(2), .WR_CYC(2)) u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_busy(cpu_busy), .sram_addr(sram_addr), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in), .sram_ce_n(sram_ce_n),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
  );

  function automatic logic [DW-1:0] init_word(input int i);
    return DW'(i) * 32'h9E37_79B1 ^ 32'h5A5A_0F0F;
  endfunction

  // Behavioural asynchronous SRAM, 15 ns access time
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_now;
  initial for (int i = 0; i < DEPTH; i++) mem[i] = init_word(i);
  always @(posedge sram_we_n) if (!sram_ce_n && sram_dq_oe) mem[sram_addr] = sram_dq_out;
  always_comb rd_now = (!sram_ce_n && !sram_oe_n) ? mem[sram_addr] : '0;
  assign #15 sram_dq_in = rd_now;

  // Bench shadow of expected contents
  logic [DW-1:0] shadow [DEPTH];
  logic [DW-1:0] last_rd;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Starts at a falling edge with busy 0; ends at a falling edge with busy 0.
  task automatic run_op(input bit is_wr, input bit both, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input bit poke);
    bit eff_wr;
    eff_wr = is_wr || both;
    cpu_addr = a; cpu_wdata = d;
    cpu_wr = eff_wr; cpu_rd = !is_wr || both;
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    if (eff_wr) shadow[a] = d;
    chk(cpu_busy == 2'd2, eff_wr ? "R3 busy load" : "R2 busy load", cpu_busy, 2);
    if (poke) begin
      // R4: requests while busy must be dropped
      cpu_addr = a ^ AW'(1); cpu_wdata = ~d; cpu_wr = 1'b1; cpu_rd = 1'b1;
    end
    #1;
    if (eff_wr) begin
      chk(sram_we_n == 1'b0, "R6 strobe low", sram_we_n, 0);
      chk(!sram_ce_n && sram_dq_oe && sram_oe_n, "R7/R8 write pins",
          {sram_ce_n, sram_dq_oe, sram_oe_n}, 3'b011);
      chk(sram_addr == a && sram_dq_out == d, "R7 write addr/data",
          {sram_addr, sram_dq_out}, {a, d});
    end else begin
      chk(!sram_ce_n && !sram_oe_n && !sram_dq_oe && sram_we_n, "R8 read pins",
          {sram_ce_n, sram_oe_n, sram_dq_oe, sram_we_n}, 4'b0001);
    end
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    chk(cpu_busy == 2'd1, poke ? "R4 busy unaffected" : "R2 busy step", cpu_busy, 1);
    #1;
    if (eff_wr) chk(sram_we_n == 1'b1, "R6 strobe rises early", sram_we_n, 1);
    @(negedge clk);
    chk(cpu_busy == 2'd0, "R3 busy done", cpu_busy, 0);
    chk(sram_ce_n && sram_oe_n && !sram_dq_oe, "R10 idle pins",
        {sram_ce_n, sram_oe_n, sram_dq_oe}, 3'b110);
    if (!eff_wr) begin
      last_rd = shadow[a];
      chk(cpu_rdata == shadow[a], "R2 read data", cpu_rdata, shadow[a]);
    end else begin
      chk(cpu_rdata == last_rd, both ? "R5 write wins, rdata held" : "R9 rdata held",
          cpu_rdata, last_rd);
      chk(mem[a] == d, "R3 written word", mem[a], d);
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) shadow[i] = init_word(i);
    last_rd = '0;
    void'($urandom(32'd20061));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cpu_busy == 0 && sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && cpu_rdata == 0,
        "R1 reset state", {cpu_busy, sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}, 5'b00111_0);
    rst = 1'b0;
    @(negedge clk);
    chk(cpu_busy == 0 && sram_ce_n && sram_we_n, "R1 after release",
        {cpu_busy, sram_ce_n, sram_we_n}, 4'b0011);

    // Directed: read initial, back-to-back write then read
    run_op(1'b0, 1'b0, 6'd5, '0, 1'b0);
    run_op(1'b1, 1'b0, 6'd9, 32'hCAFE_F00D, 1'b0);
    run_op(1'b0, 1'b0, 6'd9, '0, 1'b0);
    // R4: poke a write during a read, then confirm target untouched
    run_op(1'b0, 1'b0, 6'd12, '0, 1'b1);
    run_op(1'b0, 1'b0, 6'd13, '0, 1'b0);
    // R4: poke during a write
    run_op(1'b1, 1'b0, 6'd20, 32'h1234_5678, 1'b1);
    run_op(1'b0, 1'b0, 6'd21, '0, 1'b0);
    // R5: both strobes together -> write
    run_op(1'b0, 1'b1, 6'd30, 32'hA0B0_C0D0, 1'b0);
    run_op(1'b0, 1'b0, 6'd30, '0, 1'b0);
    // Idle gap keeps everything quiet
    repeat (3) @(negedge clk);
    chk(cpu_busy == 0 && sram_ce_n, "R10 idle gap", {cpu_busy, sram_ce_n}, 3'b001);

    // Random mix over a small address window for frequent hits
    for (int k = 0; k < 400; k++) begin
      automatic logic [AW-1:0] a = AW'($urandom % 16);
      automatic bit w = ($urandom % 2) == 1;
      automatic bit b = ($urandom % 16) == 0;
      automatic bit p = ($urandom % 8) == 0;
      run_op(w, b, a, $urandom, p);
    end
    for (int i = 0; i < 16; i++) run_op(1'b0, 1'b0, AW'(i), '0, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule